// File: doc/BRIEF.md
# Multi-Domain Clock-Enable Divider

This block turns one fast reference into five divided clock enables: processor, system bus, peripheral bus, fabric core and fabric interface. It is fully synchronous. Every output is a single-cycle enable that qualifies the fast clock `clk`. The reference itself is a tick input. The internal PLL tick (`pll_tick`) is used in normal operation. An off-chip tick (`ext_tick`) takes over when the test pins select the bypass code, which keeps the chip usable if the PLL fails.

Software-visible divider ratios are loaded through a small write port. A new ratio is held in a shadow register and reaches a domain's counter only at that domain's next terminal count. The peripheral-bus divider counts system-bus enables rather than reference ticks, so the two buses stay phase-aligned. While a debug request is active, the peripheral-bus, fabric-core and fabric-interface enables are switched off, and the processor and system bus keep running. Gating starts and stops only on a period boundary of each domain.

A mode state machine has three states: `M_NORMAL`, `M_BYPASS` and `M_DEBUG`. It moves each cycle to `M_BYPASS` when the test pins equal the bypass code. Otherwise it moves to `M_DEBUG` when a debug request is present, and to `M_NORMAL` in all other cases. Each divider has two states, `DV_RUN` and `DV_GATED`. It moves from `DV_RUN` to `DV_GATED` on a terminal count that sees a gate request, and from `DV_GATED` to `DV_RUN` on a terminal count that sees none.

Top module: `cg_clkgen`

## Requirements
- R1: After reset all enables are low, and the ratios are: processor 1, system bus 2, peripheral bus 2 (counted in bus enables, so 4 reference ticks), fabric core 2, fabric interface 13.
- R2: In normal mode, every enable other than the peripheral bus pulses once per N reference ticks of `pll_tick`, where N is the domain's ratio. The first pulse comes on the Nth tick after reset, and the pulse shares that tick's cycle.
- R3: When `test_pins` equals 4'b1001, the reference becomes `ext_tick` starting one cycle later. Any other code selects `pll_tick`.
- R4: The peripheral-bus divider counts system-bus enables, so every peripheral-bus enable coincides with a system-bus enable.
- R5: A write with `wr_en` high loads the shadow ratio selected by `wr_sel`, where 0 = processor, 1 = system bus, 2 = peripheral bus, 3 = fabric core and 4 = fabric interface. Values 5 to 7 of `wr_sel` change nothing.
- R6: A written ratio of 0 is stored as 1, which is divide-by-one.
- R7: A new ratio takes effect only after the domain's current period ends at its terminal count.
- R8: In debug mode, the peripheral-bus, fabric-core and fabric-interface enables are suppressed. The processor and system-bus enables are unaffected.
- R9: On entering debug, a gated domain still gives the pulse that closes its current period and then stops. On leaving debug, it stays silent through its next terminal count and resumes with the pulse after that.
- R10: The bypass code has priority over a debug request, and no gating is applied while bypass is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | Reference tick from the on-chip PLL |
| ext_tick | input | 1 | Reference tick from off-chip (bypass) |
| test_pins | input | 4 | Test-mode pins; 4'b1001 selects bypass |
| dbg_req | input | 1 | Debug request from the processor |
| wr_en | input | 1 | Ratio write strobe |
| wr_sel | input | 3 | Domain selector for the write |
| wr_data | input | 8 | Ratio value to write |
| en_cpu | output | 1 | Processor domain enable |
| en_bus | output | 1 | System-bus domain enable |
| en_pbus | output | 1 | Peripheral-bus domain enable |
| en_fab | output | 1 | Fabric-core domain enable |
| en_fabif | output | 1 | Fabric-interface domain enable |

## Verification
The reference is tried with tick patterns of period 1, 2, 3 and 5. Alternating `pll_tick` and `ext_tick` periods show which source the mux actually follows under each test-pin code, and a non-bypass code that differs from 4'b1001 by one bit shows that the match is exact. One run combines bypass with a debug request to separate priority from gating. Directed runs raise and drop debug in the middle of a period, which separates gating on a boundary from gating at once. A ratio is also rewritten mid-period, which separates a load on the terminal count from an immediate load.

// File: rtl/cg_pkg.sv
package cg_pkg;
    localparam int NDOM      = 5;
    localparam int DIV_W     = 8;
    localparam int IDX_CPU   = 0;
    localparam int IDX_BUS   = 1;
    localparam int IDX_PBUS  = 2;
    localparam int IDX_FAB   = 3;
    localparam int IDX_FABIF = 4;
    localparam int SEL_W     = $clog2(NDOM + 1);

    // reset ratios, processor in the low byte
    localparam logic [NDOM*DIV_W-1:0] DIV_RESET =
        {8'd13, 8'd2, 8'd2, 8'd2, 8'd1};

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_BYPASS = 2'd1,
        M_DEBUG  = 2'd2
    } mode_e;

    typedef enum logic {
        DV_RUN   = 1'b0,
        DV_GATED = 1'b1
    } dv_state_e;
endpackage

// File: rtl/cg_mode_fsm.sv
module cg_mode_fsm
    import cg_pkg::*;
#(
    parameter logic [3:0] BYPASS_CODE = 4'b1001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] test_pins,
    input  logic       dbg_req,
    output logic       use_ext,
    output logic       gate_on
);
    mode_e state_q, state_d;

    always_comb begin
        if (test_pins == BYPASS_CODE) begin
            state_d = M_BYPASS;
        end else if (dbg_req) begin
            state_d = M_DEBUG;
        end else begin
            state_d = M_NORMAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        use_ext = 1'b0;
        gate_on = 1'b0;
        unique case (state_q)
            M_NORMAL: begin
                use_ext = 1'b0;
                gate_on = 1'b0;
            end
            M_BYPASS: begin
                use_ext = 1'b1;
                gate_on = 1'b0;
            end
            M_DEBUG: begin
                use_ext = 1'b0;
                gate_on = 1'b1;
            end
            default: begin
                use_ext = 1'b0;
                gate_on = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cg_regs.sv
module cg_regs
    import cg_pkg::*;
#(
    parameter int N_DOM = NDOM,
    parameter int W     = DIV_W,
    parameter int SW    = SEL_W,
    parameter logic [N_DOM*W-1:0] RESET_VALS = DIV_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [N_DOM*W-1:0] shadow
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] wr_clamped;
    assign wr_clamped = (wr_data == '0) ? ONE : wr_data;

    for (genvar i = 0; i < N_DOM; i++) begin : g_reg
        logic [W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= RESET_VALS[i*W +: W];
            end else if (wr_en && (wr_sel == SW'(i))) begin
                val_q <= wr_clamped;
            end
        end
        assign shadow[i*W +: W] = val_q;
    end
endmodule

// File: rtl/cg_divider.sv
module cg_divider
    import cg_pkg::*;
#(
    parameter int           W       = DIV_W,
    parameter logic [W-1:0] DIV_RST = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         gate_req,
    input  logic [W-1:0] div_next,
    output logic         en
);
    dv_state_e    state_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] last;
    logic         term;

    assign last = (cur_q <= W'(1)) ? '0 : cur_q - W'(1);
    assign term = tick && (cnt_q >= last);

    // state register: decisions only on a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DV_RUN;
        end else if (term) begin
            unique case (state_q)
                DV_RUN:   if (gate_req)  state_q <= DV_GATED;
                DV_GATED: if (!gate_req) state_q <= DV_RUN;
                default:  state_q <= DV_RUN;
            endcase
        end
    end

    // period counter, ratio reload at terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= DIV_RST;
        end else if (tick) begin
            if (term) begin
                cnt_q <= '0;
                cur_q <= div_next;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    always_comb begin
        en = 1'b0;
        unique case (state_q)
            DV_RUN:   en = term;
            DV_GATED: en = 1'b0;
            default:  en = 1'b0;
        endcase
    end
endmodule

// File: rtl/cg_clkgen.sv
module cg_clkgen
    import cg_pkg::*;
#(
    parameter logic [3:0]      BYPASS_CODE = 4'b1001,
    parameter logic [NDOM-1:0] GATE_MASK   = 5'b11100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_tick,
    input  logic       ext_tick,
    input  logic [3:0] test_pins,
    input  logic       dbg_req,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       en_cpu,
    output logic       en_bus,
    output logic       en_pbus,
    output logic       en_fab,
    output logic       en_fabif
);
    logic                  use_ext;
    logic                  gate_on;
    logic                  ref_tick;
    logic                  bus_en_w;
    logic [NDOM*DIV_W-1:0] shadow;
    logic [NDOM-1:0]       dom_en;

    cg_mode_fsm #(.BYPASS_CODE(BYPASS_CODE)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_pins (test_pins),
        .dbg_req   (dbg_req),
        .use_ext   (use_ext),
        .gate_on   (gate_on)
    );

    assign ref_tick = use_ext ? ext_tick : pll_tick;

    cg_regs #(
        .N_DOM      (NDOM),
        .W          (DIV_W),
        .SW         (SEL_W),
        .RESET_VALS (DIV_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .shadow  (shadow)
    );

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        logic tick_i;
        logic en_i;

        if (i == IDX_PBUS) begin : g_from_bus
            assign tick_i = bus_en_w;
        end else begin : g_from_ref
            assign tick_i = ref_tick;
        end

        cg_divider #(
            .W       (DIV_W),
            .DIV_RST (DIV_RESET[i*DIV_W +: DIV_W])
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_i),
            .gate_req (gate_on && GATE_MASK[i]),
            .div_next (shadow[i*DIV_W +: DIV_W]),
            .en       (en_i)
        );

        if (i == IDX_BUS) begin : g_bus_tap
            assign bus_en_w = en_i;
        end

        assign dom_en[i] = en_i;
    end

    assign en_cpu   = dom_en[IDX_CPU];
    assign en_bus   = dom_en[IDX_BUS];
    assign en_pbus  = dom_en[IDX_PBUS];
    assign en_fab   = dom_en[IDX_FAB];
    assign en_fabif = dom_en[IDX_FABIF];
endmodule

// File: rtl/cg_clkgen_chk.sv
module cg_clkgen_chk #(
    parameter logic [3:0] BYPASS_CODE = 4'b1001
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_tick,
    input logic       ext_tick,
    input logic [3:0] test_pins,
    input logic       dbg_req,
    input logic       en_cpu,
    input logic       en_bus,
    input logic       en_pbus,
    input logic       en_fab,
    input logic       en_fabif
);
    logic any_en;
    logic dbg_eff_q;
    logic pb_seen_q;
    logic fb_seen_q;
    logic fi_seen_q;

    assign any_en = en_cpu | en_bus | en_pbus | en_fab | en_fabif;

    // debug as the mode logic saw it one cycle earlier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_eff_q <= 1'b0;
        end else begin
            dbg_eff_q <= dbg_req && (test_pins != BYPASS_CODE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_seen_q <= 1'b0;
            fb_seen_q <= 1'b0;
            fi_seen_q <= 1'b0;
        end else if (!dbg_eff_q) begin
            pb_seen_q <= 1'b0;
            fb_seen_q <= 1'b0;
            fi_seen_q <= 1'b0;
        end else begin
            pb_seen_q <= pb_seen_q | en_pbus;
            fb_seen_q <= fb_seen_q | en_fab;
            fi_seen_q <= fi_seen_q | en_fabif;
        end
    end

    AST_PBUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        en_pbus |-> en_bus); // R4

    AST_BYPASS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(test_pins) == BYPASS_CODE) && any_en) |-> ext_tick); // R3

    AST_NORMAL_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(test_pins) != BYPASS_CODE) && any_en) |-> pll_tick); // R2

    AST_PBUS_ONE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_eff_q && en_pbus) |-> !pb_seen_q); // R9

    AST_FAB_ONE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_eff_q && en_fab) |-> !fb_seen_q); // R8

    AST_FABIF_ONE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_eff_q && en_fabif) |-> !fi_seen_q); // R8
endmodule

bind cg_clkgen cg_clkgen_chk #(.BYPASS_CODE(BYPASS_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_tick  (pll_tick),
    .ext_tick  (ext_tick),
    .test_pins (test_pins),
    .dbg_req   (dbg_req),
    .en_cpu    (en_cpu),
    .en_bus    (en_bus),
    .en_pbus   (en_pbus),
    .en_fab    (en_fab),
    .en_fabif  (en_fabif)
);

// File: tb/cg_clkgen_tb.sv
`timescale 1ns/1ps
module cg_clkgen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic [3:0] test_pins = 4'b0000;
    logic       dbg_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       en_cpu, en_bus, en_pbus, en_fab, en_fabif;

    int n_chk = 0;
    int n_bad = 0;
    int c_cpu, c_bus, c_pbus, c_fab, c_fabif;
    int tick_no;
    int fi_pos [3];
    int fi_idx;

    always #4 clk = ~clk;

    cg_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ext_tick(ext_tick),
        .test_pins(test_pins), .dbg_req(dbg_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .en_cpu(en_cpu), .en_bus(en_bus),
        .en_pbus(en_pbus), .en_fab(en_fab), .en_fabif(en_fabif)
    );

    // vector table: pins, debug, pll period, ext period
    localparam int NV = 5;
    localparam logic [3:0] V_PINS [NV] = '{4'b0000, 4'b1001, 4'b1000, 4'b1001, 4'b1001};
    localparam logic       V_DBG  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam int         V_PLL  [NV] = '{1, 1, 2, 2, 3};
    localparam int         V_EXT  [NV] = '{3, 3, 1, 5, 1};
    localparam int         WIN = 120;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        c_cpu = 0; c_bus = 0; c_pbus = 0; c_fab = 0; c_fabif = 0;
        tick_no = 0; fi_idx = 0;
    endtask

    task automatic step(input logic pt, input logic et, input logic dbg);
        @(negedge clk);
        pll_tick = pt; ext_tick = et; dbg_req = dbg;
        #1;
        if (pt) tick_no++;
        c_cpu   += int'(en_cpu);
        c_bus   += int'(en_bus);
        c_pbus  += int'(en_pbus);
        c_fab   += int'(en_fab);
        c_fabif += int'(en_fabif);
        if (en_fabif && fi_idx < 3) begin
            fi_pos[fi_idx] = tick_no;
            fi_idx++;
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        pll_tick = 1'b0; ext_tick = 1'b0;
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] pins, input logic dbg);
        @(negedge clk);
        rst_n = 1'b0; test_pins = pins; dbg_req = dbg;
        pll_tick = 1'b0; ext_tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, dbg);
        step(1'b0, 1'b0, dbg);
        clr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state with no reference
        do_reset(4'b0000, 1'b0);
        chk("R1 idle enables", int'({en_cpu, en_bus, en_pbus, en_fab, en_fabif}), 0);

        // table-driven reference selection and division
        for (int v = 0; v < NV; v++) begin
            int ticks;
            int per;
            do_reset(V_PINS[v], V_DBG[v]);
            ticks = 0;
            per = (V_PINS[v] == 4'b1001) ? V_EXT[v] : V_PLL[v];
            for (int s = 1; s <= WIN; s++) begin
                step((s % V_PLL[v]) == 0, (s % V_EXT[v]) == 0, V_DBG[v]);
                if ((s % per) == 0) ticks++;
            end
            chk($sformatf("R1/R2/R3 v%0d cpu", v), c_cpu, ticks);
            chk($sformatf("R2/R3 v%0d bus", v), c_bus, ticks / 2);
            chk($sformatf("R4 v%0d pbus", v), c_pbus, (ticks / 2) / 2);
            chk($sformatf("R2/R10 v%0d fab", v), c_fab, ticks / 2);
            chk($sformatf("R1/R10 v%0d fabif", v), c_fabif, ticks / 13);
        end

        // R5 R6 R7: ratio writes
        do_reset(4'b0000, 1'b0);
        wr(3'd0, 8'd0);   // processor ratio 0 -> 1
        wr(3'd1, 8'd0);   // bus ratio 0 -> 1
        wr(3'd4, 8'd2);   // fabric interface ratio 2
        wr(3'd5, 8'd7);   // unused selector
        wr(3'd7, 8'd3);   // unused selector
        clr();
        for (int s = 1; s <= 20; s++) step(1'b1, 1'b0, 1'b0);
        chk("R6 cpu zero ratio", c_cpu, 20);
        chk("R6 bus zero ratio after first period", c_bus, 19);
        chk("R5 pbus counts bus", c_pbus, 9);
        chk("R5 fab untouched by sel 5/7", c_fab, 10);
        chk("R7 fabif first pulse old ratio", fi_pos[0], 13);
        chk("R7 fabif second pulse new ratio", fi_pos[1], 15);
        chk("R7 fabif third pulse", fi_pos[2], 17);

        // R8 R9: debug entry and exit mid-period
        do_reset(4'b0000, 1'b0);
        for (int s = 1; s <= 19; s++) step(1'b1, 1'b0, 1'b0);
        clr();
        for (int s = 20; s <= 80; s++) step(1'b1, 1'b0, 1'b1);
        chk("R8 cpu runs in debug", c_cpu, 61);
        chk("R8 bus runs in debug", c_bus, 31);
        chk("R9 pbus tail on entry", c_pbus, 2);
        chk("R9 fab tail on entry", c_fab, 2);
        chk("R9 fabif tail on entry", c_fabif, 1);
        clr();
        for (int s = 81; s <= 110; s++) step(1'b1, 1'b0, 1'b0);
        chk("R9 fab resumes after boundary", c_fab, 14);
        chk("R9 pbus resumes after boundary", c_pbus, 6);
        chk("R9 fabif resumes after boundary", c_fabif, 1);
        chk("R8 cpu after debug", c_cpu, 30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule